// File: doc/BRIEF.md
# Multi-Rate TDM Serial Line Bank

This block terminates 24 time-division-multiplexed serial lines and turns them into bytes, and back again. Each line carries 64 kb/s channels of eight bits. The line rate is selected by a mode input: 2.048, 4.096 or 8.192 Mb/s, giving 32, 64 or 128 channels per frame. The block runs from a single bit clock at twice the line rate, so every bit occupies two clock cycles. An active-low frame pulse realigns the channel counter to the start of a frame.

On the transmit side, the byte side offers one byte per line together with a tristate bit per line. The block latches that set at the boundary of each channel and shifts it out most significant bit first. At the top rate the bank has a fixed split: the lower half of the lines only receive and the upper half only transmit. At the two lower rates every line is bidirectional. In those modes a channel whose tristate bit is clear is driven, and its transmitted byte is reported back on the receive path in place of the line level. On the receive side, each completed channel is presented as one byte per line, with a per-line valid strobe.

Top module: `tdm_serial_port`

## Requirements
- R1: `mode` 00 selects 32 channels per frame, 01 selects 64, and 10 or 11 selects 128. A bit lasts two clock cycles and a channel lasts 16 cycles. `cur_ch` counts up and wraps to 0 after the last channel of the selected rate.
- R2: When `fp_n` is low at a rising edge, the following cycle is the first clock of channel 0, bit 7, whatever the counter held before.
- R3: Each channel is sent bit 7 first and bit 0 last. `line_o` changes only at the start of a bit and holds for both cycles of that bit.
- R4: A line is sampled at the rising edge that ends the second cycle of each bit. The eight samples form the received byte, with the first sample as bit 7.
- R5: `tx_data` and `tx_hiz` are latched together at the edge that ends a channel, or at a frame-pulse edge, and apply to the channel that starts next. Line g uses bits 8g+7..8g of `tx_data` and bit g of `tx_hiz`.
- R6: In modes 00 and 01, `line_oe[g]` is 1 (driven) exactly when the latched `tx_hiz[g]` is 0.
- R7: In the 128-channel mode, lines 0..11 are never driven and lines 12..23 are always driven, whatever `tx_hiz` holds. Only lines 0..11 raise `rx_valid`.
- R8: In modes 00 and 01, a driven channel's received byte equals the byte transmitted on that line, and `line_i` is ignored for it. An undriven channel is captured from `line_i`.
- R9: `rx_valid` pulses for one cycle, in the first cycle after a channel ends. `rx_data` bits 8g+7..8g then hold line g's byte, and they keep that value until the line's next valid.
- R10: After reset the counter sits at channel 0, bit 7, first cycle. All latched tristate bits are 1, so no bidirectional line is driven. `rx_valid` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twice the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Rate select; change only while in reset |
| fp_n | input | 1 | Active-low frame pulse |
| line_i | input | 24 | Serial line levels in |
| line_o | output | 24 | Serial line levels out |
| line_oe | output | 24 | Per-line drive enable, 1 = driven |
| tx_data | input | 192 | Transmit byte per line for the next channel |
| tx_hiz | input | 24 | Tristate bit per line for the next channel, 1 = high impedance |
| rx_data | output | 192 | Last received byte per line |
| rx_valid | output | 24 | One-cycle strobe per line, new byte available |
| cur_ch | output | 7 | Channel currently on the lines |

## Verification
Each rate is run with random line levels, random transmit bytes and random tristate bits, so that driven and undriven channels mix on every line. That mix separates the loopback path from the line capture path. At the top rate the same random tristate bits must leave the fixed split untouched. Frame pulses arrive both on the natural frame boundary, where they must change nothing, and once in the middle of a frame, where they must restart channel 0 and load fresh transmit data. Every clock the outputs are compared against a behavioural model of bit, channel and byte timing.

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int NLINES = 24,
  parameter int CHW    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic                  fp_n,
  input  logic [NLINES-1:0]     line_i,
  output logic [NLINES-1:0]     line_o,
  output logic [NLINES-1:0]     line_oe,
  input  logic [NLINES*8-1:0]   tx_data,
  input  logic [NLINES-1:0]     tx_hiz,
  output logic [NLINES*8-1:0]   rx_data,
  output logic [NLINES-1:0]     rx_valid,
  output logic [CHW-1:0]        cur_ch
);
  localparam int NSPLIT = NLINES / 2;
  localparam int BW     = NLINES * 8;

  logic                ph;
  logic [2:0]          bidx;
  logic [CHW-1:0]      ch;
  logic [CHW-1:0]      last_ch;
  logic [BW-1:0]       hold;
  logic [NLINES-1:0]   hiz_q;
  logic                wide, ch_end, load;

  assign wide    = mode[1];
  assign last_ch = wide    ? {CHW{1'b1}} :
                   mode[0] ? CHW'((1 << (CHW-1)) - 1) :
                             CHW'((1 << (CHW-2)) - 1);
  assign ch_end  = ph && (bidx == 3'd0);
  assign load    = !fp_n || ch_end;
  assign cur_ch  = ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      bidx <= 3'd7;
      ch   <= '0;
    end else if (!fp_n) begin
      ph   <= 1'b0;
      bidx <= 3'd7;
      ch   <= '0;
    end else if (!ph) begin
      ph <= 1'b1;
    end else begin
      ph <= 1'b0;
      if (bidx == 3'd0) begin
        bidx <= 3'd7;
        ch   <= (ch == last_ch) ? '0 : ch + 1'b1;
      end else begin
        bidx <= bidx - 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      hiz_q <= '1;
    end else if (load) begin
      hold  <= tx_data;
      hiz_q <= tx_hiz;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [7:0] txb;
    logic [7:0] sr;
    logic       fb, keep;

    assign txb        = hold[g*8 +: 8];
    assign line_o[g]  = txb[bidx];
    assign line_oe[g] = wide ? (g >= NSPLIT) : !hiz_q[g];
    assign keep       = wide ? (g < NSPLIT) : 1'b1;
    assign fb         = (!wide && !hiz_q[g]) ? txb[bidx] : line_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sr                <= '0;
        rx_data[g*8 +: 8] <= '0;
        rx_valid[g]       <= 1'b0;
      end else begin
        rx_valid[g] <= ch_end && keep;
        if (ph) sr <= {sr[6:0], fb};
        if (ch_end && keep) rx_data[g*8 +: 8] <= {sr[6:0], fb};
      end
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ch <= last_ch);
  assert_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> (ch == '0 && bidx == 3'd7 && !ph));
  assert_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph |-> $stable(line_o));
  assert_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> (rx_valid[NLINES-1:NSPLIT] == '0));
  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> (bidx == 3'd7 && !ph));
endmodule

// File: tb/tb_tdm_serial_port.sv
module tb_tdm_serial_port;
  localparam int NL = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic            fp_n = 1'b1;
  logic [NL-1:0]   line_i = '0;
  logic [NL-1:0]   line_o, line_oe;
  logic [NL*8-1:0] tx_data = '0;
  logic [NL-1:0]   tx_hiz = '1;
  logic [NL*8-1:0] rx_data;
  logic [NL-1:0]   rx_valid;
  logic [6:0]      cur_ch;

  always #10 clk = ~clk;

  tdm_serial_port dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fp_n(fp_n),
    .line_i(line_i), .line_o(line_o), .line_oe(line_oe),
    .tx_data(tx_data), .tx_hiz(tx_hiz),
    .rx_data(rx_data), .rx_valid(rx_valid), .cur_ch(cur_ch)
  );

  int vectors = 0;
  int fails = 0;
  int wd = 0;
  bit done = 0;

  int            m_ph, m_bit, m_ch;
  logic [7:0]    m_hold [NL];
  logic [NL-1:0] m_hiz;
  logic [7:0]    m_sr [NL];
  logic [7:0]    m_rxd [NL];
  logic [NL-1:0] m_rxv;

  function automatic int last_of(input logic [1:0] md);
    return md[1] ? 127 : (md[0] ? 63 : 31);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_bit = 7; m_ch = 0; m_hiz = '1; m_rxv = '0;
      for (int i = 0; i < NL; i++) begin
        m_hold[i] = 8'h00; m_sr[i] = 8'h00; m_rxd[i] = 8'h00;
      end
    end else begin
      logic endc;
      logic b;
      endc  = (m_ph == 1) && (m_bit == 0);
      m_rxv = '0;
      if (m_ph == 1) begin
        for (int i = 0; i < NL; i++) begin
          b = (!mode[1] && !m_hiz[i]) ? m_hold[i][m_bit] : line_i[i];
          m_sr[i] = {m_sr[i][6:0], b};
          if (endc && (!mode[1] || i < NL/2)) begin
            m_rxd[i] = m_sr[i];
            m_rxv[i] = 1'b1;
          end
        end
      end
      if (!fp_n || endc) begin
        for (int i = 0; i < NL; i++) m_hold[i] = tx_data[i*8 +: 8];
        m_hiz = tx_hiz;
      end
      if (!fp_n) begin
        m_ph = 0; m_bit = 7; m_ch = 0;
      end else if (m_ph == 0) begin
        m_ph = 1;
      end else begin
        m_ph = 0;
        if (m_bit == 0) begin
          m_bit = 7;
          m_ch = (m_ch == last_of(mode)) ? 0 : m_ch + 1;
        end else begin
          m_bit = m_bit - 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [NL*8-1:0] act, input logic [NL*8-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [NL-1:0]   eo, eoe;
    logic [NL*8-1:0] erx;
    for (int i = 0; i < NL; i++) begin
      eo[i] = m_hold[i][m_bit];
      erx[i*8 +: 8] = m_rxd[i];
    end
    eoe = mode[1] ? {{(NL/2){1'b1}}, {(NL/2){1'b0}}} : ~m_hiz;
    check(cur_ch == 7'(m_ch), "R1 channel count", {185'd0, cur_ch}, 192'(m_ch));
    check(line_o == eo, "R3 line data", {168'd0, line_o}, {168'd0, eo});
    check(line_oe == eoe, mode[1] ? "R7 fixed split" : "R6 tristate",
          {168'd0, line_oe}, {168'd0, eoe});
    check(rx_valid == m_rxv, "R9 valid strobe", {168'd0, rx_valid}, {168'd0, m_rxv});
    check(rx_data == erx, mode[1] ? "R4 line capture" : "R8 loopback/capture",
          rx_data, erx);
  endtask

  task automatic run_mode(input logic [1:0] md, input int frames);
    int len, inj;
    logic [NL*8-1:0] saved;
    logic [NL-1:0] e7;
    rst_n = 1'b0;
    fp_n  = 1'b1;
    mode  = md;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(cur_ch == 7'd0 && rx_valid == '0 && rx_data == '0, "R10 reset state",
          {168'd0, rx_valid}, 192'd0);
    if (!md[1])
      check(line_oe == '0, "R10 reset undriven", {168'd0, line_oe}, 192'd0);
    len = (last_of(md) + 1) * 16;
    inj = len + len / 3 + 5;
    saved = '0;
    for (int cyc = 0; cyc < frames * len; cyc++) begin
      @(negedge clk);
      compare_all();
      if (cyc == inj + 1) begin
        for (int i = 0; i < NL; i++) e7[i] = saved[i*8 + 7];
        check(cur_ch == 7'd0, "R2 frame realign", {185'd0, cur_ch}, 192'd0);
        check(line_o == e7, "R5 load on frame pulse", {168'd0, line_o}, {168'd0, e7});
      end
      line_i  = NL'($urandom);
      tx_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      tx_hiz  = ($urandom % 4 == 0) ? '1 : NL'($urandom);
      fp_n    = !(m_ph == 1 && m_bit == 0 && m_ch == last_of(md));
      if (cyc == inj) begin
        fp_n  = 1'b0;
        saved = tx_data;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    run_mode(2'b00, 3);
    run_mode(2'b01, 3);
    run_mode(2'b10, 3);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule